// File: doc/BRIEF.md
# Pseudo-SRAM Strobe Sequencer

This block sits between a clocked host and a 16-bit low-power pseudo-SRAM that has asynchronous, active-low strobes. The host side uses a request/ready handshake. A request carries a direction, an 18-bit word address, a burst length (`len_i` + 1 words, up to 16), two byte enables and the first write word. The controller then generates the chip-select, output-enable, write-enable and byte-strobe waveforms. It also drives the address bus and a split data bus with its own drive-enable. Each timing window is a clock count, computed as the ceiling of the time in nanoseconds over `CLK_PERIOD_NS`.

A burst runs as a page access. The first word needs a full random-access window. Each later read word needs only the shorter page window. Each later write word repeats a write-enable pulse. The memory refreshes itself internally, so chip select may not stay low too long and must rise for a minimum gap between accesses. For that reason the controller ends a page early in two cases: when the next word would cross a 16-word aligned boundary, and when it would push the chip-select-low time past its limit. In either case it raises chip select for the gap and resumes at the next address.

For reads, one `rvalid_o` pulse per word presents that word's data. For writes, one `wack_o` pulse per word tells the host to put the next word on `wdata_i`.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, `ready_o` is 1, `ce_no`, `oe_no`, `we_no`, `ub_no` and `lb_no` are 1, and `dq_oe_o` is 0.
- R2: A request is accepted on a clock edge with `req_i`=1 and `ready_o`=1. For a read, chip select and output enable stay low for C_RC cycles. C_RC is the larger of ceil(70 ns/period) and ceil(25 ns/period), which is 4 at 20 ns. The first `rvalid_o` appears C_RC+1 falling edges after `req_i` is driven.
- R3: `rdata_o` carries `dq_i` captured on the last cycle of the word window. Bits [7:0] are kept only if `be[0]`=1, and bits [15:8] only if `be[1]`=1; a disabled lane reads as 0.
- R4: A burst transfers exactly `len_i`+1 words at consecutive addresses, with one `rvalid_o` or `wack_o` pulse per word. Within a page, read words after the first follow each other every C_PC = ceil(25 ns/period) cycles.
- R5: A page never crosses a 16-word aligned boundary. After a word whose address has low bits 4'hF, chip select rises before the burst continues.
- R6: A single chip-select-low period never exceeds C_CSMAX = floor(`T_CSMAX_NS`/period) cycles. A burst that would exceed it is split into several accesses.
- R7: Chip select stays high for at least C_CP = max(1, ceil(10 ns/period)) cycles between accesses.
- R8: Output enable goes low only during read transactions, and never while write enable is low.
- R9: `dq_oe_o` is 1 only while chip select is low during a write, and it is 1 in every write-enable-low cycle. It is 0 in the cycle before output enable falls.
- R10: During a write, write enable stays low for at least C_WF = 3 cycles per word at 20 ns. The byte strobes are `lb_no` = !`be[0]` and `ub_no` = !`be[1]`, and `dq_o` holds the host word.
- R11: `ready_o` stays 0 from acceptance until the final chip-select-high gap ends, and chip select is high whenever `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Start word address |
| len_i | input | 4 | Burst length minus one |
| be_i | input | 2 | Byte enables, bit 0 low byte |
| wdata_i | input | 16 | Write word (first, then the next after each `wack_o`) |
| ready_o | output | 1 | Idle, request accepted |
| rdata_o | output | 16 | Read word |
| rvalid_o | output | 1 | Read word valid pulse |
| wack_o | output | 1 | Write word done pulse |
| ce_no | output | 1 | Memory chip select, active low |
| oe_no | output | 1 | Memory output enable, active low |
| we_no | output | 1 | Memory write enable, active low |
| ub_no | output | 1 | Upper byte strobe, active low |
| lb_no | output | 1 | Lower byte strobe, active low |
| maddr_o | output | 18 | Memory address |
| dq_o | output | 16 | Data driven to memory |
| dq_oe_o | output | 1 | Data bus drive enable |
| dq_i | input | 16 | Data from memory |

## Verification
The hardest case to reach is the chip-select-low limit. At the default it is thousands of cycles, while even a full 16-word page lasts only tens of cycles, so it can never trigger. The bench therefore builds the controller with a 300 ns limit (15 cycles). That makes 16-word reads and writes split into several accesses. Further bursts start a few words before a 16-word boundary, so that page splits happen both from the boundary rule and from the time limit. The bench computes the expected number of chip-select-low periods from those two rules and compares it with the count it sees.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WLO,
    S_WHI,
    S_GAP
  } seq_st_e;

  function automatic int cdiv(input int t_ns, input int per_ns);
    return (t_ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i - W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);

  // a zero-length window would collapse the strobe timing
  p_load_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (val_i != '0));

endmodule

// File: rtl/psram_cs_guard.sv
module psram_cs_guard #(
  parameter int LIMIT = 8000,
  parameter int TW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_low_i,
  input  logic [TW-1:0] cost_i,
  output logic          fits_o
);

  localparam int CW = $clog2(LIMIT + 1) + 1;
  localparam int SW = (CW > TW ? CW : TW) + 2;

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cs_low_i) cnt_q <= cnt_q + CW'(1);
    else               cnt_q <= '0;
  end

  // cycles used so far including this one, plus the next word
  assign sum    = SW'(cnt_q) + SW'(cost_i) + SW'(1);
  assign fits_o = (sum <= SW'(LIMIT));

  p_cs_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_low_i |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int LEN_W         = 4,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 70,
  parameter int T_OE_NS       = 25,
  parameter int T_PC_NS       = 25,
  parameter int T_WC_NS       = 70,
  parameter int T_WP_NS       = 50,
  parameter int T_CW_NS       = 60,
  parameter int T_DW_NS       = 20,
  parameter int T_CP_NS       = 10,
  parameter int T_CSMAX_NS    = 160000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        be_i,
  input  logic [15:0]       wdata_i,
  output logic              ready_o,
  output logic [15:0]       rdata_o,
  output logic              rvalid_o,
  output logic              wack_o,
  output logic              ce_no,
  output logic              oe_no,
  output logic              we_no,
  output logic              ub_no,
  output logic              lb_no,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [15:0]       dq_o,
  output logic              dq_oe_o,
  input  logic [15:0]       dq_i
);

  localparam int C_RC    = imax(cdiv(T_RC_NS, CLK_PERIOD_NS), cdiv(T_OE_NS, CLK_PERIOD_NS));
  localparam int C_PC    = imax(1, cdiv(T_PC_NS, CLK_PERIOD_NS));
  localparam int C_CP    = imax(1, cdiv(T_CP_NS, CLK_PERIOD_NS));
  localparam int C_WF    = imax(imax(cdiv(T_WP_NS, CLK_PERIOD_NS), cdiv(T_CW_NS, CLK_PERIOD_NS)),
                                imax(cdiv(T_DW_NS, CLK_PERIOD_NS), cdiv(T_WC_NS, CLK_PERIOD_NS) - 1));
  localparam int C_WL    = imax(imax(cdiv(T_WP_NS, CLK_PERIOD_NS), cdiv(T_DW_NS, CLK_PERIOD_NS)),
                                cdiv(T_PC_NS, CLK_PERIOD_NS) - 1);
  localparam int C_CSMAX = T_CSMAX_NS / CLK_PERIOD_NS;
  localparam int C_TOP   = imax(imax(C_RC, C_PC), imax(imax(C_CP, C_WF), C_WL + 1));
  localparam int TW      = $clog2(C_TOP + 1) + 1;
  localparam int PG_W    = LEN_W;

  seq_st_e             st_q, st_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [1:0]          be_q;
  logic                wr_q;
  logic [LEN_W:0]      left_q;
  logic [15:0]         dq_q;
  logic [15:0]         rdata_q;
  logic                rvalid_q, wack_q;

  logic                ld;
  logic [TW-1:0]       ld_val;
  logic                t_done;
  logic                word_done;
  logic                last_word, page_end, fits, cont;
  logic [TW-1:0]       cost;
  logic                cs_low;

  assign last_word = (left_q == (LEN_W+1)'(1));
  assign page_end  = &addr_q[PG_W-1:0];
  assign cont      = !last_word && !page_end && fits;
  assign cost      = wr_q ? TW'(C_WL + 1) : TW'(C_PC);
  assign cs_low    = (st_q == S_RD) || (st_q == S_WLO) || (st_q == S_WHI);

  psram_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .done_o (t_done)
  );

  psram_cs_guard #(.LIMIT(C_CSMAX), .TW(TW)) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_low_i (cs_low),
    .cost_i   (cost),
    .fits_o   (fits)
  );

  always_comb begin
    st_d      = st_q;
    ld        = 1'b0;
    ld_val    = TW'(C_CP);
    word_done = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_i) begin
        ld     = 1'b1;
        st_d   = we_i ? S_WLO : S_RD;
        ld_val = we_i ? TW'(C_WF) : TW'(C_RC);
      end
      S_RD: if (t_done) begin
        word_done = 1'b1;
        ld        = 1'b1;
        if (cont) ld_val = TW'(C_PC);
        else      st_d   = S_GAP;
      end
      S_WLO: if (t_done) begin
        word_done = 1'b1;
        if (cont) st_d = S_WHI;
        else begin
          st_d = S_GAP;
          ld   = 1'b1;
        end
      end
      S_WHI: begin
        st_d   = S_WLO;
        ld     = 1'b1;
        ld_val = TW'(C_WL);
      end
      S_GAP: if (t_done) begin
        if (left_q == '0) st_d = S_IDLE;
        else begin
          ld     = 1'b1;
          st_d   = wr_q ? S_WLO : S_RD;
          ld_val = wr_q ? TW'(C_WF) : TW'(C_RC);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      addr_q   <= '0;
      be_q     <= '0;
      wr_q     <= 1'b0;
      left_q   <= '0;
      dq_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      wack_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      rvalid_q <= 1'b0;
      wack_q   <= 1'b0;
      if (st_q == S_IDLE && req_i) begin
        addr_q <= addr_i;
        be_q   <= be_i;
        wr_q   <= we_i;
        left_q <= {1'b0, len_i} + (LEN_W+1)'(1);
        dq_q   <= wdata_i;
      end
      if (word_done) begin
        left_q <= left_q - (LEN_W+1)'(1);
        if (!last_word) addr_q <= addr_q + ADDR_W'(1);
        if (wr_q) wack_q <= 1'b1;
        else begin
          rdata_q  <= dq_i & {{8{be_q[1]}}, {8{be_q[0]}}};
          rvalid_q <= 1'b1;
        end
      end
      // next write word taken as a new strobe window opens
      if (st_d == S_WLO && (st_q == S_WHI || st_q == S_GAP)) dq_q <= wdata_i;
    end
  end

  assign ready_o  = (st_q == S_IDLE);
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign wack_o   = wack_q;
  assign ce_no    = !cs_low;
  assign oe_no    = (st_q != S_RD);
  assign we_no    = (st_q != S_WLO);
  assign dq_oe_o  = (st_q == S_WLO) || (st_q == S_WHI);
  assign ub_no    = !cs_low || !be_q[1];
  assign lb_no    = !cs_low || !be_q[0];
  assign maddr_o  = addr_q;
  assign dq_o     = dq_q;

  // cs-high run length, for gap check only
  logic [TW-1:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hi_run_q <= TW'(C_CP);
    else if (!ce_no)                 hi_run_q <= '0;
    else if (hi_run_q != {TW{1'b1}}) hi_run_q <= hi_run_q + TW'(1);
  end

  p_cs_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ce_no) |-> (hi_run_q >= TW'(C_CP)));

  p_oe_not_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (we_no && !wr_q));

  p_bus_off_on_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !dq_oe_o);

  p_bus_released_before_oe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_no) |-> $past(!dq_oe_o));

  p_we_drives_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (dq_oe_o && !ce_no));

  p_ready_deselect_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ce_no);

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rvalid_o && wack_o));

endmodule

// File: tb/psram_ctrl_tb_top.sv
module psram_ctrl_tb_top;

  localparam int PER    = 20;
  localparam int RD_F   = 4;
  localparam int RD_N   = 2;
  localparam int WR_F   = 3;
  localparam int WR_N   = 4;
  localparam int CSMAX  = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [3:0]  len = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic        ready, rvalid, wack, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [17:0] maddr;

  always #(PER/2) clk = ~clk;

  psram_ctrl #(.CLK_PERIOD_NS(PER), .T_CSMAX_NS(300)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .len_i(len), .be_i(be), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata),
    .rvalid_o(rvalid), .wack_o(wack), .ce_no(ce_n), .oe_no(oe_n), .we_no(we_n),
    .ub_no(ub_n), .lb_no(lb_n), .maddr_o(maddr), .dq_o(dq_o), .dq_oe_o(dq_oe),
    .dq_i(dq_i)
  );

  // memory model
  logic [15:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = '0;
  assign dq_i = (!ce_n && !oe_n) ?
      {ub_n ? 8'hEE : mem[maddr[7:0]][15:8], lb_n ? 8'hEE : mem[maddr[7:0]][7:0]} : 16'h0;
  always @(negedge clk) if (!ce_n && !we_n && dq_oe) begin
    if (!lb_n) mem[maddr[7:0]][7:0]  <= dq_o[7:0];
    if (!ub_n) mem[maddr[7:0]][15:8] <= dq_o[15:8];
  end

  int tests = 0, fails = 0, m_tests = 0, m_fails = 0;
  int seg_cnt = 0;
  logic cur_wr = 1'b0;
  logic [1:0] cur_be = '0;

  // pin-level monitor
  logic ce_p = 1'b1, oe_p = 1'b1, we_p = 1'b1, dqoe_p = 1'b0;
  int ce_run = 0, we_run = 0;
  always @(negedge clk) if (rst_n) begin
    if (ce_p && !ce_n) seg_cnt++;
    ce_run = ce_n ? 0 : ce_run + 1;
    if (!ce_p && ce_n) begin
      m_tests++;
      if (ce_run_prev > CSMAX) begin m_fails++; $display("FAIL R6 cs low run %0d exp <= %0d", ce_run_prev, CSMAX); end
    end
    if (we_p && !we_n) begin
      m_tests++;
      if (lb_n != !cur_be[0] || ub_n != !cur_be[1] || !dq_oe) begin
        m_fails++; $display("FAIL R10 strobes lb=%b ub=%b oe=%b exp lb=%b ub=%b oe=1", lb_n, ub_n, dq_oe, !cur_be[0], !cur_be[1]);
      end
    end
    we_run = we_n ? 0 : we_run + 1;
    if (!we_p && we_n) begin
      m_tests++;
      if (we_run_prev < WR_F) begin m_fails++; $display("FAIL R10 we low run %0d exp >= %0d", we_run_prev, WR_F); end
    end
    if (!oe_n && (cur_wr || !we_n)) begin m_fails++; $display("FAIL R8 oe low wr=%b we_n=%b exp read only", cur_wr, we_n); end
    if (!oe_n && dq_oe) begin m_fails++; $display("FAIL R9 dq_oe=1 with oe low exp 0"); end
    if (oe_p && !oe_n && dqoe_p) begin m_fails++; $display("FAIL R9 dq_oe=1 before oe fall exp 0"); end
    if (ready && !ce_n) begin m_fails++; $display("FAIL R11 ce_n=0 with ready exp 1"); end
    ce_p = ce_n; oe_p = oe_n; we_p = we_n; dqoe_p = dq_oe;
    ce_run_prev = ce_run; we_run_prev = we_run;
  end
  int ce_run_prev = 0, we_run_prev = 0;

  logic [15:0] ref_m [256];
  initial for (int i = 0; i < 256; i++) ref_m[i] = '0;

  function automatic logic [15:0] wd(input logic [17:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h11};
  endfunction

  function automatic int exp_segs(input logic w, input logic [17:0] a0, input int n0);
    int s = 0, n = n0, used;
    logic [17:0] a = a0;
    while (n > 0) begin
      s++; used = w ? WR_F : RD_F; n--;
      while (n > 0 && a[3:0] != 4'hF && used + (w ? WR_N : RD_N) <= CSMAX) begin
        used += w ? WR_N : RD_N; a++; n--;
      end
      a++;
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", rq, act, exp); end
  endtask

  int lat, rv_prev, rv_gap_min;

  task automatic txn(input logic w, input logic [17:0] a, input logic [3:0] l, input logic [1:0] b);
    int words = 0, cyc = 0;
    logic [17:0] ca = a;
    @(negedge clk);
    while (!ready) @(negedge clk);
    cur_wr = w; cur_be = b; seg_cnt = 0;
    req = 1'b1; we = w; addr = a; len = l; be = b; wdata = wd(a);
    lat = -1; rv_prev = -1; rv_gap_min = 1000;
    @(negedge clk); req = 1'b0; cyc = 1;
    while (1) begin
      if (rvalid) begin
        logic [15:0] e = ref_m[ca[7:0]] & {{8{b[1]}}, {8{b[0]}}};
        chk(rdata == e, "R3 read data", rdata, e);
        if (lat < 0) lat = cyc;
        if (rv_prev >= 0 && cyc - rv_prev < rv_gap_min) rv_gap_min = cyc - rv_prev;
        rv_prev = cyc; ca++; words++;
      end
      if (wack) begin
        if (b[0]) ref_m[ca[7:0]][7:0]  = wd(ca)[7:0];
        if (b[1]) ref_m[ca[7:0]][15:8] = wd(ca)[15:8];
        ca++; words++; wdata = wd(ca);
      end
      if (ready || cyc > 2000) break;
      @(negedge clk); cyc++;
    end
    chk(words == int'(l) + 1, "R4 word count", words, int'(l) + 1);
    chk(seg_cnt == exp_segs(w, a, int'(l) + 1), "R5 R6 cs segments", seg_cnt, exp_segs(w, a, int'(l) + 1));
  endtask

  // {we, addr, len, be}
  localparam logic [24:0] VEC [10] = '{
    {1'b1, 18'h00010, 4'd3,  2'b11},
    {1'b0, 18'h00010, 4'd3,  2'b11},
    {1'b1, 18'h0001E, 4'd3,  2'b11},
    {1'b0, 18'h0001C, 4'd7,  2'b11},
    {1'b1, 18'h00040, 4'd0,  2'b01},
    {1'b1, 18'h00041, 4'd0,  2'b10},
    {1'b0, 18'h00040, 4'd1,  2'b11},
    {1'b1, 18'h00050, 4'd15, 2'b11},
    {1'b0, 18'h00050, 4'd15, 2'b11},
    {1'b0, 18'h0005D, 4'd5,  2'b11}
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests + m_tests, fails + m_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready && ce_n && oe_n && we_n && ub_n && lb_n && !dq_oe, "R1 reset outputs",
        {ready, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe}, 7'b1111110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready && ce_n, "R11 idle after reset", {ready, ce_n}, 2'b11);

    for (int i = 0; i < 10; i++)
      txn(VEC[i][24], VEC[i][23:6], VEC[i][5:2], VEC[i][1:0]);

    // R2 single-read latency
    txn(1'b0, 18'h00011, 4'd0, 2'b11);
    chk(lat == RD_F + 1, "R2 first read latency", lat, RD_F + 1);
    // R4 page spacing within one page
    txn(1'b0, 18'h00010, 4'd3, 2'b11);
    chk(rv_gap_min == RD_N, "R4 page word spacing", rv_gap_min, RD_N);
    // R3 lane masking: upper only
    txn(1'b0, 18'h00012, 4'd0, 2'b10);
    chk(rdata[7:0] == 8'h00, "R3 disabled lane zero", rdata[7:0], 0);
    // R11 ready low during access, back high at the end
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 18'h20; len = 4'd0; be = 2'b11;
    @(negedge clk); req = 1'b0;
    chk(!ready, "R11 ready low after accept", ready, 0);
    repeat (12) @(negedge clk);
    chk(ready && ce_n, "R11 ready after access", {ready, ce_n}, 2'b11);

    $display("[TB] %0d tests run, %0d failed", tests + m_tests, fails + m_fails);
    $finish;
  end

endmodule